// File: doc/BRIEF.md
# Prescaled Free-Running Timebase

This block is the common time reference of a multi-channel timer peripheral. A programmable divider turns the input clock into a tick strobe. The timer channels use that strobe, and the same strobe advances a free-running up-counter that is twice the bus width (64 bits at the default 32-bit bus). Software owns three things: a control word with two enable bits, the divider reload value, and the counter. The counter can only be read, in two bus accesses.

Reading the low half copies the upper half into a shadow register. A high-half read that follows then returns the upper bits that belong with the low bits already returned, even if the counter carried across the half boundary between the two accesses. Two small state machines hold the state of the block:

- The divider state machine has two states, `PS_OFF` and `PS_RUN`. A control write with bit 2 set takes `PS_OFF` to `PS_RUN` (transition "arm"). A control write with bit 2 clear takes `PS_RUN` back to `PS_OFF` (transition "disarm"). The current state is read back as control bit 2.
- The snapshot state machine has two states, `SNAP_IDLE` and `SNAP_HELD`. A low-word read goes from `SNAP_IDLE` to `SNAP_HELD` (transition "capture"). A further low-word read stays in `SNAP_HELD` and captures again ("recapture"). A high-word read goes from `SNAP_HELD` back to `SNAP_IDLE` (transition "consume").

Top module: `ftb_timebase`

## Requirements
- R1: The reload register at byte offset 0x4 is DATA_W bits wide and reads back the value last written to it.
- R2: The control register is at offset 0x8. Bit 0 enables the counter and bit 2 enables the divider. All other bits are ignored on write and read back as zero.
- R3: While the divider is enabled with reload value N, `tick_o` is high for one cycle in every N+1. The first pulse comes N cycles after the cycle in which the enable was written. While the divider is disabled, `tick_o` stays low.
- R4: A write to the reload register restarts the divider from zero. The next pulse then comes N cycles after that write.
- R5: The counter increases by one on each tick while control bit 0 is set. It holds its value while bit 0 is clear, and also while the divider is off.
- R6: The counter is 2*DATA_W bits wide and wraps from all-ones to zero.
- R7: A read at offset 0x0 returns the low half of the count and captures the high half. The next read at offset 0x10 returns the captured high half.
- R8: A read at offset 0x10 with no capture pending returns the live high half of the count.
- R9: Writes to offsets 0x0 and 0x10 change nothing. Reads of unmapped offsets return zero.
- R10: After reset, all registers, the count and the divider are zero, and `tick_o` is low.
- R11: The read data is valid, with `rvalid_o` high, in the cycle after the read strobe. It reflects the state before that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data |
| rvalid_o | output | 1 | Read data valid |
| tick_o | output | 1 | Prescaled tick strobe |

## Verification
A divider phase that is off by one shows up at `tick_o` within one divide period after an enable or a reload write. It also shows up as a wrong count in the next low-word read after a timed run. A snapshot state machine stuck in the wrong state is exposed by the first high-word read issued just after a low-half carry: the high half differs between the live and the captured value. A narrow or non-wrapping counter shows up on the first read after the all-ones value. The bench uses an 8-bit bus, so both the carry and the wrap can be reached in a short run.

// File: rtl/ftb_pkg.sv
package ftb_pkg;

    localparam logic [4:0] OFF_CNT_LO = 5'h00;
    localparam logic [4:0] OFF_RELOAD = 5'h04;
    localparam logic [4:0] OFF_CTRL   = 5'h08;
    localparam logic [4:0] OFF_CNT_HI = 5'h10;

    localparam int CTRL_CNT_BIT = 0;
    localparam int CTRL_DIV_BIT = 2;

    typedef enum logic {
        PS_OFF = 1'b0,
        PS_RUN = 1'b1
    } ps_state_e;

    typedef enum logic {
        SNAP_IDLE = 1'b0,
        SNAP_HELD = 1'b1
    } snap_state_e;

endpackage

// File: rtl/ftb_prescaler.sv
module ftb_prescaler
    import ftb_pkg::*;
#(
    parameter int DIV_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ctrl_we_i,
    input  logic             div_en_bit_i,
    input  logic             reload_we_i,
    input  logic [DIV_W-1:0] reload_i,
    output logic             running_o,
    output logic             tick_o
);

    ps_state_e        state_q, state_d;
    logic [DIV_W-1:0] div_q;
    logic             at_top;

    assign at_top = (div_q == reload_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_OFF: if (ctrl_we_i && div_en_bit_i)  state_d = PS_RUN;  // arm
            PS_RUN: if (ctrl_we_i && !div_en_bit_i) state_d = PS_OFF;  // disarm
            default: state_d = PS_OFF;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= PS_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= '0;
        end else if (state_q == PS_OFF || reload_we_i) begin
            div_q <= '0;
        end else if (at_top) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    always_comb begin
        running_o = 1'b0;
        tick_o    = 1'b0;
        unique case (state_q)
            PS_OFF: begin
                running_o = 1'b0;
                tick_o    = 1'b0;
            end
            PS_RUN: begin
                running_o = 1'b1;
                tick_o    = at_top;
            end
            default: ;
        endcase
    end

    AST_TICK_ONLY_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> (state_q == PS_RUN)) else $error("tick while off");  // R3
    AST_DIV_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reload_we_i |=> (div_q == '0)) else $error("divider not restarted");  // R4
    AST_DIV_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == PS_RUN && !reload_we_i && !at_top) |=> (div_q == $past(div_q) + DIV_W'(1)))
        else $error("divider step");  // R3

endmodule

// File: rtl/ftb_counter.sv
module ftb_counter
    import ftb_pkg::*;
#(
    parameter int HALF_W = 32,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              inc_i,
    input  logic              lo_rd_i,
    input  logic              hi_rd_i,
    output logic [HALF_W-1:0] lo_word_o,
    output logic [HALF_W-1:0] hi_word_o
);

    logic [CNT_W-1:0]  count_q;
    logic [HALF_W-1:0] shadow_q;
    snap_state_e       snap_q, snap_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            count_q <= '0;
        end else if (inc_i) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    always_comb begin
        snap_d = snap_q;
        unique case (snap_q)
            SNAP_IDLE: if (lo_rd_i) snap_d = SNAP_HELD;  // capture
            SNAP_HELD: if (hi_rd_i) snap_d = SNAP_IDLE;  // consume (low read: recapture)
            default:   snap_d = SNAP_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            snap_q <= SNAP_IDLE;
        end else begin
            snap_q <= snap_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            shadow_q <= '0;
        end else if (lo_rd_i) begin
            shadow_q <= count_q[CNT_W-1:HALF_W];
        end
    end

    always_comb begin
        lo_word_o = count_q[HALF_W-1:0];
        hi_word_o = count_q[CNT_W-1:HALF_W];
        unique case (snap_q)
            SNAP_IDLE: hi_word_o = count_q[CNT_W-1:HALF_W];
            SNAP_HELD: hi_word_o = shadow_q;
            default:   ;
        endcase
    end

    AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !inc_i |=> $stable(count_q)) else $error("count moved without tick");  // R5
    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inc_i |=> (count_q == $past(count_q) + CNT_W'(1))) else $error("count step");  // R6
    AST_SNAP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (snap_q == SNAP_HELD && !lo_rd_i) |=> $stable(shadow_q)) else $error("shadow lost");  // R7
    AST_SNAP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(lo_rd_i && hi_rd_i)) else $error("both halves read at once");  // R7

endmodule

// File: rtl/ftb_regbank.sv
module ftb_regbank
    import ftb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              div_running_i,
    input  logic [DATA_W-1:0] lo_word_i,
    input  logic [DATA_W-1:0] hi_word_i,
    output logic              ctrl_we_o,
    output logic              reload_we_o,
    output logic              cnt_en_o,
    output logic [DATA_W-1:0] reload_o,
    output logic              lo_rd_o,
    output logic              hi_rd_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    logic              sel_lo, sel_hi, sel_rl, sel_ct;
    logic              cnt_en_q;
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    assign sel_lo = (addr_i == ADDR_W'(OFF_CNT_LO));
    assign sel_hi = (addr_i == ADDR_W'(OFF_CNT_HI));
    assign sel_rl = (addr_i == ADDR_W'(OFF_RELOAD));
    assign sel_ct = (addr_i == ADDR_W'(OFF_CTRL));

    assign ctrl_we_o   = wr_en_i && sel_ct;
    assign reload_we_o = wr_en_i && sel_rl;
    assign lo_rd_o     = rd_en_i && sel_lo;
    assign hi_rd_o     = rd_en_i && sel_hi;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_en_q <= 1'b0;
            reload_q <= '0;
        end else begin
            if (ctrl_we_o)   cnt_en_q <= wdata_i[CTRL_CNT_BIT];
            if (reload_we_o) reload_q <= wdata_i;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (sel_lo) begin
            rd_mux = lo_word_i;
        end else if (sel_hi) begin
            rd_mux = hi_word_i;
        end else if (sel_rl) begin
            rd_mux = reload_q;
        end else if (sel_ct) begin
            rd_mux[CTRL_CNT_BIT] = cnt_en_q;
            rd_mux[CTRL_DIV_BIT] = div_running_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_en_i;
            if (rd_en_i) rdata_q <= rd_mux;
        end
    end

    assign cnt_en_o = cnt_en_q;
    assign reload_o = reload_q;
    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;

    AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i |=> rvalid_o) else $error("missing read valid");  // R11
    AST_CNT_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (sel_lo || sel_hi)) |=> ($stable(cnt_en_q) && $stable(reload_q)))
        else $error("count write changed state");  // R9

endmodule

// File: rtl/ftb_timebase.sv
module ftb_timebase
    import ftb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic              tick_o
);

    logic              ctrl_we, reload_we, cnt_en, div_running, tick;
    logic              lo_rd, hi_rd;
    logic [DATA_W-1:0] reload_val, lo_word, hi_word;

    ftb_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .wr_en_i       (wr_en_i),
        .rd_en_i       (rd_en_i),
        .addr_i        (addr_i),
        .wdata_i       (wdata_i),
        .div_running_i (div_running),
        .lo_word_i     (lo_word),
        .hi_word_i     (hi_word),
        .ctrl_we_o     (ctrl_we),
        .reload_we_o   (reload_we),
        .cnt_en_o      (cnt_en),
        .reload_o      (reload_val),
        .lo_rd_o       (lo_rd),
        .hi_rd_o       (hi_rd),
        .rdata_o       (rdata_o),
        .rvalid_o      (rvalid_o)
    );

    ftb_prescaler #(.DIV_W(DATA_W)) u_div (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .ctrl_we_i    (ctrl_we),
        .div_en_bit_i (wdata_i[CTRL_DIV_BIT]),
        .reload_we_i  (reload_we),
        .reload_i     (reload_val),
        .running_o    (div_running),
        .tick_o       (tick)
    );

    ftb_counter #(.HALF_W(DATA_W)) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .inc_i     (tick && cnt_en),
        .lo_rd_i   (lo_rd),
        .hi_rd_i   (hi_rd),
        .lo_word_o (lo_word),
        .hi_word_o (hi_word)
    );

    assign tick_o = tick;

    AST_NO_COUNT_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !div_running |-> !tick_o) else $error("tick without divider");  // R5

endmodule

// File: tb/ftb_timebase_test.sv
module ftb_timebase_test;

    localparam int DW = 8;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;
    logic          tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [DW-1:0] exp;
        string         tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #4 clk = ~clk;

    ftb_timebase #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
        .tick_o(tick)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // All bus tasks start and end on a falling edge.
    task automatic reg_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        sb_q.push_back('{exp: e, tag: tag});
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Monitor: pops one expected item per valid read result.
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (sb_q.size() == 0) begin
                check(32'd1, 32'd0, "R11 unexpected read data");
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                check(32'(rdata), 32'(it.exp), it.tag);
            end
        end
    end

    initial begin
        int ticks;
        repeat (3) @(negedge clk);
        check(32'(tick), 32'd0, "R10 tick in reset");
        rst_n = 1'b1;
        @(negedge clk);

        reg_rd(5'h00, 8'h00, "R10 count low after reset");
        reg_rd(5'h10, 8'h00, "R10 count high after reset");
        reg_rd(5'h04, 8'h00, "R10 reload after reset");
        reg_rd(5'h08, 8'h00, "R10 control after reset");
        check(32'(tick), 32'd0, "R10 tick idle");

        reg_wr(5'h04, 8'hA5);
        reg_rd(5'h04, 8'hA5, "R1 reload readback");
        reg_wr(5'h08, 8'hFA);
        reg_rd(5'h08, 8'h00, "R2 reserved control bits");
        reg_rd(5'h0C, 8'h00, "R9 unmapped read");

        // Counter enabled but divider off: no movement.
        reg_wr(5'h08, 8'h01);
        reg_rd(5'h08, 8'h01, "R2 counter enable bit");
        repeat (20) @(negedge clk);
        check(32'(tick), 32'd0, "R3 no tick while divider off");
        reg_rd(5'h00, 8'h00, "R5 hold while divider off");
        reg_wr(5'h08, 8'h00);

        // Divider alone, reload 2: 10 ticks in 30 cycles, count still 0.
        reg_wr(5'h04, 8'h02);
        reg_wr(5'h08, 8'h04);
        ticks = 0;
        for (int i = 0; i < 30; i++) begin
            if (tick) ticks++;
            if (i < 30) @(negedge clk);
        end
        check(32'(ticks), 32'd10, "R3 tick rate reload 2");
        reg_rd(5'h08, 8'h04, "R2 divider enable bit");
        reg_rd(5'h00, 8'h00, "R5 hold while counter off");
        reg_wr(5'h08, 8'h00);
        @(negedge clk);
        check(32'(tick), 32'd0, "R3 tick low after disable");

        // Both enabled, reload 2, 30 cycles -> 10 counts.
        reg_wr(5'h08, 8'h05);
        repeat (29) @(negedge clk);
        reg_wr(5'h08, 8'h00);
        reg_rd(5'h00, 8'd10, "R5 count after reload 2 run");
        // Reload 4, 24 cycles -> 4 more counts.
        reg_wr(5'h04, 8'h04);
        reg_wr(5'h08, 8'h05);
        repeat (23) @(negedge clk);
        reg_wr(5'h08, 8'h00);
        reg_rd(5'h00, 8'd14, "R5 count after reload 4 run");

        // Writes to count offsets are ignored.
        reg_wr(5'h00, 8'hAA);
        reg_wr(5'h10, 8'h55);
        reg_rd(5'h00, 8'd14, "R9 low unchanged after write");
        reg_rd(5'h10, 8'h00, "R9 high unchanged after write");
        reg_rd(5'h04, 8'h04, "R9 reload unchanged after write");

        // Reload 0: count advances every cycle from 14.
        reg_wr(5'h04, 8'h00);
        reg_wr(5'h08, 8'h05);
        repeat (497) @(negedge clk);
        reg_rd(5'h00, 8'hFF, "R7 low word before carry");
        reg_rd(5'h10, 8'h01, "R7 high word from capture");
        reg_rd(5'h10, 8'h02, "R8 live high word");
        repeat (65021) @(negedge clk);
        reg_rd(5'h00, 8'hFF, "R6 low word at all-ones");
        reg_rd(5'h10, 8'hFF, "R6 high word at all-ones");
        reg_rd(5'h00, 8'h01, "R6 low word after wrap");
        reg_rd(5'h10, 8'h00, "R6 high word after wrap");
        reg_wr(5'h08, 8'h00);

        // Reload write restarts the divider.
        reg_wr(5'h04, 8'h03);
        reg_wr(5'h08, 8'h04);
        repeat (5) @(negedge clk);
        reg_wr(5'h04, 8'h03);
        check(32'(tick), 32'd0, "R4 restart phase 0");
        @(negedge clk);
        check(32'(tick), 32'd0, "R4 restart phase 1");
        @(negedge clk);
        check(32'(tick), 32'd0, "R4 restart phase 2");
        @(negedge clk);
        check(32'(tick), 32'd1, "R4 restart phase 3");
        reg_wr(5'h08, 8'h00);

        repeat (3) @(negedge clk);
        check(32'(sb_q.size()), 32'd0, "R11 all reads answered");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule